// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter with Dual Count Enables

This block is a binary up counter in which every state bit is updated on the same rising clock edge. Four operations are available: a synchronous clear, a synchronous parallel load, counting, and hold. Clear and load act only at the clock edge, never immediately.

Two count enables gate the counter. The run enable only qualifies counting. The carry enable qualifies counting and also gates the combinational carry output. The carry output is high when the carry enable is high and the count is all ones. Because of this, several stages can be chained: the carry output of one stage drives the carry enable of the next. The run enable of every stage can then be shared.

The block has no reset input. Its first defined value comes from asserting clear for one clock.

Top module: `ctr_sync_preset`

## Requirements
- R1: While clear_i is 1, count_o becomes 0 on the next rising edge of clk. count_o does not change before that edge.
- R2: While load_i is 1 and clear_i is 0, data_i is copied into count_o on the next rising edge.
- R3: When clear_i and load_i are both 1, clear takes priority and count_o becomes 0.
- R4: Load takes priority over counting. With load_i at 1 and both enables at 1, count_o takes data_i and not the incremented value.
- R5: When clear_i and load_i are 0 and cnt_en_i and carry_en_i are both 1, count_o increases by one on each edge. Bit i toggles only when all bits below it are 1. Bit 0 toggles on every such edge, so 0111 goes to 1000.
- R6: When clear_i and load_i are 0 and either enable is 0, count_o keeps its value.
- R7: Counting from all ones goes to zero in a single edge, with no intermediate value visible at any sampled point.
- R8: carry_o is combinational and equals carry_en_i AND (count_o == all ones). It follows carry_en_i within the same cycle.
- R9: When cnt_en_i is 0 and carry_en_i is 1 at all ones, count_o holds and carry_o stays 1.
- R10: Two stages form a counter of twice the width, counting modulo 2^(2*WIDTH). In this arrangement the lower stage's carry_o drives the upper stage's carry_en_i, and cnt_en_i is shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every state bit (rising edge) |
| clear_i | input | 1 | Synchronous clear, active high, highest priority |
| load_i | input | 1 | Synchronous parallel load, active high |
| data_i | input | WIDTH | Value captured on load |
| cnt_en_i | input | 1 | Run enable; qualifies counting only |
| carry_en_i | input | 1 | Carry enable; qualifies counting and gates carry_o |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry for the next stage |

## Verification
Counting is first driven with both enables held high from zero through a full wrap. This separates a correct carry chain from one that toggles upper bits too early, and it catches a wrap that passes through intermediate values. Each enable is then dropped on its own, at a mid-range value and at all ones. This distinguishes the run enable, which only freezes the count, from the carry enable, which also kills the carry output. Clear and load are asserted together and against active counting to expose the priority order. A chained pair then counts through several hundred edges, which checks that the carry from the lower stage advances the upper stage exactly once per lower wrap.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;

endpackage

// File: rtl/ctr_op_sel.sv
module ctr_op_sel
    import ctr_pkg::*;
(
    input  logic    clear_i,
    input  logic    load_i,
    input  logic    cnt_en_i,
    input  logic    carry_en_i,
    output ctr_op_e op_o
);
    // Priority: clear, then load, then counting, else hold.
    always_comb begin
        if (clear_i)                     op_o = OP_CLEAR;
        else if (load_i)                 op_o = OP_LOAD;
        else if (cnt_en_i && carry_en_i) op_o = OP_STEP;
        else                             op_o = OP_HOLD;
    end

    always_comb begin
        if (clear_i) a_clear_first_r3: assert (op_o == OP_CLEAR);
    end
endmodule

// File: rtl/ctr_toggle_chain.sv
module ctr_toggle_chain #(
    parameter int WIDTH = 4
) (
    input  logic             run_i,
    input  logic [WIDTH-1:0] q_i,
    output logic [WIDTH-1:0] tog_o
);
    // Each bit toggles when the run condition holds and every lower bit is one.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign tog_o[i] = run_i;
        end else begin : g_upper
            assign tog_o[i] = tog_o[i-1] & q_i[i-1];
        end
    end
endmodule

// File: rtl/ctr_carry_out.sv
module ctr_carry_out #(
    parameter int WIDTH = 4
) (
    input  logic             carry_en_i,
    input  logic [WIDTH-1:0] q_i,
    output logic             carry_o
);
    assign carry_o = carry_en_i & (&q_i);
endmodule

// File: rtl/ctr_sync_preset.sv
module ctr_sync_preset
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             cnt_en_i,
    input  logic             carry_en_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO     = '0;

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } ctr_state_t;

    ctr_state_t       state_d, state_q;
    ctr_op_e          op;
    logic [WIDTH-1:0] tog;

    ctr_op_sel u_op_sel (
        .clear_i    (clear_i),
        .load_i     (load_i),
        .cnt_en_i   (cnt_en_i),
        .carry_en_i (carry_en_i),
        .op_o       (op)
    );

    ctr_toggle_chain #(.WIDTH(WIDTH)) u_chain (
        .run_i (op == OP_STEP),
        .q_i   (state_q.count),
        .tog_o (tog)
    );

    ctr_carry_out #(.WIDTH(WIDTH)) u_carry (
        .carry_en_i (carry_en_i),
        .q_i        (state_q.count),
        .carry_o    (carry_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_CLEAR: state_d.count = ZERO;
            OP_LOAD:  state_d.count = data_i;
            OP_STEP:  state_d.count = state_q.count ^ tog;
            default:  state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count_o = state_q.count;

    // Assertion gating: the count is defined only after the first clear.
    logic primed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (clear_i) primed_q <= 1'b1;
    end

    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!primed_q)
        clear_i |=> count_o == ZERO);

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!primed_q)
        (load_i && !clear_i) |=> count_o == $past(data_i));

    p_count_step_r5: assert property (@(posedge clk) disable iff (!primed_q)
        (!clear_i && !load_i && cnt_en_i && carry_en_i)
        |=> count_o == WIDTH'($past(count_o) + 1'b1));

    p_hold_r6: assert property (@(posedge clk) disable iff (!primed_q)
        (!clear_i && !load_i && !(cnt_en_i && carry_en_i)) |=> $stable(count_o));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!primed_q)
        (carry_o && cnt_en_i && !clear_i && !load_i) |=> count_o == ZERO);

    p_carry_hold_r9: assert property (@(posedge clk) disable iff (!primed_q)
        (carry_o && !cnt_en_i && carry_en_i && !clear_i && !load_i)
        |=> (count_o == ALL_ONES));
endmodule

// File: tb/tb_ctr_sync_preset.sv
module tb_ctr_sync_preset;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clear_i = 1'b0, load_i = 1'b0, cnt_en_i = 1'b0, carry_en_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic [W-1:0] count_o;
    logic         carry_o;

    logic         hi_clear = 1'b0;
    logic [W-1:0] hi_count;
    logic         hi_carry;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    ctr_sync_preset #(.WIDTH(W)) dut (
        .clk(clk), .clear_i(clear_i), .load_i(load_i), .data_i(data_i),
        .cnt_en_i(cnt_en_i), .carry_en_i(carry_en_i),
        .count_o(count_o), .carry_o(carry_o)
    );

    ctr_sync_preset #(.WIDTH(W)) dut_hi (
        .clk(clk), .clear_i(hi_clear), .load_i(1'b0), .data_i('0),
        .cnt_en_i(cnt_en_i), .carry_en_i(carry_o),
        .count_o(hi_count), .carry_o(hi_carry)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Inputs change at negedge; one rising edge passes; outputs sampled at the next negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(logic c, logic l, logic [W-1:0] d, logic p, logic t);
        clear_i = c; load_i = l; data_i = d; cnt_en_i = p; carry_en_i = t;
    endtask

    task automatic t_clear();
        drive(0, 1, 4'd9, 0, 0);
        tick();
        drive(1, 0, 4'd0, 0, 0);
        #1 check("R1 before edge", count_o, 9);
        tick();
        check("R1 after edge", count_o, 0);
    endtask

    task automatic t_load();
        int vals[3] = '{5, 10, 15};
        foreach (vals[k]) begin
            drive(0, 1, W'(vals[k]), 0, 0);
            tick();
            check("R2 load", count_o, vals[k]);
        end
    endtask

    task automatic t_clear_over_load();
        drive(0, 1, 4'd9, 0, 0);
        tick();
        drive(1, 1, 4'd6, 1, 1);
        tick();
        check("R3 clear wins", count_o, 0);
    endtask

    task automatic t_load_over_count();
        drive(0, 1, 4'd7, 0, 0);
        tick();
        drive(0, 1, 4'd3, 1, 1);
        tick();
        check("R4 load wins", count_o, 3);
    endtask

    task automatic t_count();
        int ref_v;
        drive(1, 0, 0, 0, 0);
        tick();
        ref_v = 0;
        drive(0, 0, 0, 1, 1);
        for (int k = 0; k < 20; k++) begin
            tick();
            ref_v = (ref_v + 1) % 16;
            check(ref_v == 0 ? "R7 wrap" : "R5 step", count_o, ref_v);
        end
        drive(0, 1, 4'd7, 0, 0);
        tick();
        drive(0, 0, 0, 1, 1);
        tick();
        check("R5 0111 to 1000", count_o, 8);
    endtask

    task automatic t_hold();
        drive(0, 1, 4'd6, 0, 0);
        tick();
        drive(0, 0, 0, 0, 1);
        tick(); tick();
        check("R6 run enable low", count_o, 6);
        drive(0, 0, 0, 1, 0);
        tick(); tick();
        check("R6 carry enable low", count_o, 6);
        drive(0, 0, 0, 0, 0);
        tick();
        check("R6 both low", count_o, 6);
    endtask

    task automatic t_carry();
        drive(0, 1, 4'd15, 0, 0);
        tick();
        #1 check("R8 carry gated off", carry_o, 0);
        carry_en_i = 1'b1;
        #1 check("R8 carry follows enable", carry_o, 1);
        load_i = 1'b0;
        tick(); tick();
        check("R9 count holds", count_o, 15);
        check("R9 carry stays", carry_o, 1);
        carry_en_i = 1'b0;
        #1 check("R8 carry drops", carry_o, 0);
        drive(0, 1, 4'd14, 0, 1);
        tick();
        check("R8 no carry at 14", carry_o, 0);
        drive(0, 0, 0, 1, 1);
        tick();
        check("R8 carry at 15", carry_o, 1);
        tick();
        check("R7 single-edge wrap", count_o, 0);
    endtask

    task automatic t_cascade();
        int ref_v;
        drive(1, 0, 0, 0, 0);
        hi_clear = 1'b1;
        tick();
        hi_clear = 1'b0;
        drive(0, 0, 0, 1, 1);
        ref_v = 0;
        for (int k = 0; k < 300; k++) begin
            tick();
            ref_v = (ref_v + 1) % 256;
            check("R10 cascade", {hi_count, count_o}, ref_v);
        end
        cnt_en_i = 1'b0;
        tick();
        check("R10 cascade hold", {hi_count, count_o}, ref_v);
    endtask

    initial begin : watchdog
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_clear();
        t_load();
        t_clear_over_load();
        t_load_over_count();
        t_count();
        t_hold();
        t_carry();
        t_cascade();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule